// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the word address for a four-beat cache-line burst. A start strobe loads the full address from the address bus, and the low two bits of the output begin at the loaded value. Each cycle that the advance input is active, the low two bits step to the next beat, in linear or interleaved order. The high bits keep the loaded value for the whole burst. After the fourth beat the sequence wraps to the first beat and repeats until another start.

Two start strobes are provided. The processor strobe counts only while the first chip select is active. The cache-controller strobe is never gated. Any accepted strobe restarts the sequence, even in the middle of a burst. The ordering mode is a static level input. The memory array and the data path are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, addr_out is all zeros and burst_active is 0.
- R2: A rising edge with proc_strb_n=0 and sel1_n=0 loads addr_in. From the next cycle addr_out equals the loaded value (beat index 0).
- R3: When sel1_n=1, proc_strb_n=0 is ignored. With ctrl_strb_n=1 and adv_n=1, addr_out and burst_active keep their values.
- R4: A rising edge with ctrl_strb_n=0 loads addr_in whatever the level of sel1_n. From the next cycle addr_out equals the loaded value.
- R5: An accepted strobe during a burst reloads the address and resets the beat index to 0. In the cycle of an accepted strobe, adv_n has no effect.
- R6: With burst_active=1 and no accepted strobe, adv_n=0 moves the beat index forward by one per cycle. adv_n=1 holds addr_out.
- R7: With ileave=0 (linear), the low two bits of addr_out are (start low bits + beat index) mod 4.
- R8: With ileave=1 (interleaved), the low two bits of addr_out are the start low bits XOR the beat index.
- R9: Bits 16:2 of addr_out change only on an accepted strobe.
- R10: After beat index 3, one more advance brings the beat index back to 0, so addr_out equals the loaded address again.
- R11: burst_active rises in the cycle after the first accepted strobe and stays 1 until reset.
- R12: Before any accepted strobe, adv_n=0 leaves addr_out at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strb_n | input | 1 | Processor start strobe, active low, gated by sel1_n |
| ctrl_strb_n | input | 1 | Cache-controller start strobe, active low, never gated |
| adv_n | input | 1 | Advance to the next beat, active low |
| sel1_n | input | 1 | First chip select, active low; qualifies proc_strb_n |
| ileave | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_in | input | 17 | Start address bus |
| addr_out | output | 17 | Current burst word address |
| burst_active | output | 1 | A start address has been loaded since reset |

## Verification
The bench builds the block with its default 17-bit address and 2-bit beat counter, so a full four-beat wrap takes only a few cycles. That lets every start offset and both orderings be swept in both modes. Directed sequences cover the gated processor strobe, the ungated controller strobe, a restart in mid-burst and holds on the advance input. A long random phase with full-width addresses shows that the high bits stay fixed while the low bits walk and wrap.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // beat ordering applied to the low address bits
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_q,
   output logic              active_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         base_q   <= addr_in;
         active_q <= 1'b1;
      end
   end

   // R11
   active_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |=> active_q);

endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end

   // R10
   beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && cnt_q == LAST) |=> (cnt_q == '0));

   // R5
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_addr_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             order,
   input  logic [CNT_W-1:0] start_lo,
   input  logic [CNT_W-1:0] beat,
   output logic [CNT_W-1:0] addr_lo
);

   logic [CNT_W-1:0] lin_lo;
   logic [CNT_W-1:0] ilv_lo;

   assign lin_lo = start_lo + beat;

   for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
      assign ilv_lo[b] = start_lo[b] ^ beat[b];
   end

   always_comb begin
      if (burst_order_e'(order) == ORD_INTERLEAVE)
         addr_lo = ilv_lo;
      else
         addr_lo = lin_lo;
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int ADDR_W = 17,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_strb_n,
   input  logic              ctrl_strb_n,
   input  logic              adv_n,
   input  logic              sel1_n,
   input  logic              ileave,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic              burst_active
);

   localparam int HI_W = ADDR_W - CNT_W;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (ADDR_W <= CNT_W) begin : g_bad_addr
      $error("ADDR_W must exceed CNT_W");
   end

   logic              proc_ok;
   logic              start;
   logic              step;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  beat_q;
   logic [CNT_W-1:0]  lo_bits;

   assign proc_ok = !proc_strb_n && !sel1_n;
   assign start   = proc_ok || !ctrl_strb_n;
   assign step    = burst_active && !adv_n && !start;

   burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .addr_in  (addr_in),
      .base_q   (base_q),
      .active_q (burst_active)
   );

   burst_step_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .step  (step),
      .cnt_q (beat_q)
   );

   burst_order_map #(.CNT_W(CNT_W)) u_map (
      .order    (ileave),
      .start_lo (base_q[CNT_W-1:0]),
      .beat     (beat_q),
      .addr_lo  (lo_bits)
   );

   assign addr_out = {base_q[ADDR_W-1:CNT_W], lo_bits};

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (addr_out == $past(addr_in)));

   // R3
   proc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strb_n && sel1_n && ctrl_strb_n && adv_n) |=> $stable(addr_out));

   // R6
   adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_n && !start) |=> $stable(addr_out));

   // R9
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

   // R12
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_active && !start) |=> (addr_out == '0));

   initial begin
      assert (HI_W > 0);
   end

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        proc_strb_n, ctrl_strb_n, adv_n, sel1_n, ileave;
   logic [16:0] addr_in;
   logic [16:0] addr_out;
   logic        burst_active;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // behavioural reference state
   int m_base  = 0;
   int m_beat  = 0;
   bit m_act   = 0;

   always #2 clk = ~clk;

   burst_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n),
      .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .sel1_n(sel1_n),
      .ileave(ileave), .addr_in(addr_in), .addr_out(addr_out),
      .burst_active(burst_active)
   );

   function automatic int expect_addr();
      int lo;
      if (ileave) lo = (m_base % 4) ^ m_beat;
      else        lo = ((m_base % 4) + m_beat) % 4;
      return (m_base / 4) * 4 + lo;
   endfunction

   task automatic idle_inputs();
      proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1; sel1_n = 0;
   endtask

   // one clock: update model at the edge, compare at the falling edge
   task automatic cyc(input string tag);
      int ex;
      @(posedge clk);
      if (!rst_n) begin
         m_base = 0; m_beat = 0; m_act = 0;
      end else if ((!proc_strb_n && !sel1_n) || !ctrl_strb_n) begin
         m_base = int'(addr_in); m_beat = 0; m_act = 1;
      end else if (m_act && !adv_n) begin
         m_beat = (m_beat + 1) % 4;
      end
      @(negedge clk);
      ex = expect_addr();
      checks++;
      if (int'(addr_out) !== ex || burst_active !== m_act) begin
         errors++;
         $display("FAIL %s: addr_out=%h active=%b expected addr=%h active=%b",
                  tag, addr_out, burst_active, ex[16:0], m_act);
      end
   endtask

   task automatic run_mode(input bit mode, input string otag);
      rst_n = 0; idle_inputs(); ileave = mode; addr_in = 17'h1FFFF;
      cyc("R1"); cyc("R1");
      rst_n = 1;
      cyc("R1");
      // R12: advance with no burst loaded
      adv_n = 0; cyc("R12"); cyc("R12"); adv_n = 1;
      // R2: processor start, all four start offsets
      for (int off = 0; off < 4; off++) begin
         addr_in = 17'h1ABC0 | 17'(off);
         proc_strb_n = 0; cyc("R2"); proc_strb_n = 1;
         adv_n = 0;
         for (int k = 0; k < 6; k++) cyc(k < 3 ? otag : "R10");
         adv_n = 1;
         cyc("R6"); cyc("R6");
      end
      // R3: blocked processor strobe
      sel1_n = 1; addr_in = 17'h00005; proc_strb_n = 0;
      cyc("R3"); cyc("R3");
      proc_strb_n = 1;
      // R4: controller strobe while sel1_n inactive
      addr_in = 17'h0F00E; ctrl_strb_n = 0; cyc("R4"); ctrl_strb_n = 1;
      sel1_n = 0;
      adv_n = 0; cyc(otag); cyc(otag);
      // R5: restart in mid-burst, advance held low through it
      addr_in = 17'h15553; ctrl_strb_n = 0; cyc("R5"); ctrl_strb_n = 1;
      cyc("R5"); cyc("R11");
      adv_n = 1;
      // R9: random traffic with wide addresses
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom % 16;
         proc_strb_n = (r == 0) ? 1'b0 : 1'b1;
         ctrl_strb_n = (r == 1) ? 1'b0 : 1'b1;
         sel1_n      = $urandom % 2;
         adv_n       = $urandom % 3 == 0;
         addr_in     = 17'($urandom);
         cyc("R9");
      end
      idle_inputs();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle_inputs(); ileave = 0; addr_in = '0;
      @(negedge clk);
      run_mode(1'b0, "R7");
      run_mode(1'b1, "R8");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule